// File: doc/BRIEF.md
# Framed Byte-Stream Receiver with Double-Banked Frame Store

This block takes bytes from an external USB bridge chip over an 8-bit synchronous FIFO bus that runs on the bridge's own 60 MHz clock. It drives the active-low output-enable and read strobes and watches the active-low receive-ready flag from the bridge. The incoming stream is cut into frames. Each frame starts with three equal sync bytes (0xA5 by default), then carries one command byte that is dropped, then a fixed-length payload (2048 bytes by default). The payload is written into one bank of a two-bank frame store.

When a payload is complete, the producer side switches to the other bank. The bank number crosses into the 50 MHz system domain through a two-flop synchroniser. There it produces a one-cycle frame-ready pulse and updates the bank the consumer reads through its own registered read port. The sync hunt restarts after every frame. A lost or extra byte can therefore spoil at most the frame it lands in and the frame after it. It never shifts the alignment of the frames that follow.

The bus side has three named states. BUS_IDLE goes to BUS_OE when the ready flag is low, otherwise it stays. BUS_OE goes to BUS_READ when the flag is still low, otherwise it returns to BUS_IDLE. BUS_READ stays while the flag is low and returns to BUS_IDLE when it goes high.

The framer has three named states, and it steps only on a captured byte. FR_HUNT counts matching sync bytes and moves to FR_CMD on the third. FR_CMD moves to FR_DATA on the next byte. FR_DATA returns to FR_HUNT after the last payload byte and toggles the bank.

Top module: `frame_fifo_rx`

## Requirements
- R1: After reset, and in idle while rxf_n is high, oe_n and rd_n stay high. After reset, frame_ready is 0 and frame_bank is 1.
- R2: oe_n goes low one bus clock before rd_n goes low. The two never fall on the same edge.
- R3: If rxf_n is high at a bus edge while rd_n is low, oe_n and rd_n are both high after that edge.
- R4: A byte is taken from bus_data only at a bus edge where rd_n is low and rxf_n is low. No empty or stale byte is stored at the start of a burst.
- R5: A frame starts only after three consecutive sync bytes of value 0xA5. Any other byte during the hunt resets the match count to zero.
- R6: The byte after the sync bytes is a command byte. It is discarded even when its value is 0xA5.
- R7: Payload bytes go to addresses 0 to 2047 of the producer bank, in arrival order. A pause with rxf_n high keeps the frame position.
- R8: After the 2048th payload byte, the producer bank toggles and the sync hunt restarts.
- R9: Each completed frame gives exactly one frame_ready pulse of one system clock. In the same cycle, frame_bank changes to the bank just completed. frame_bank changes at no other time.
- R10: rd_data shows the byte at rd_addr in bank frame_bank, one system clock after rd_addr is applied.
- R11: Suppose a frame loses payload bytes. After that frame and the one following it, the next frame that starts with sync bytes is stored with no offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | FIFO bus clock from the bridge (60 MHz) |
| bus_rst_n | input | 1 | Active-low reset, bus domain |
| rxf_n | input | 1 | Active-low: bridge has a byte available |
| bus_data | input | 8 | Byte driven by the bridge |
| oe_n | output | 1 | Active-low output enable to the bridge |
| rd_n | output | 1 | Active-low read strobe to the bridge |
| sys_clk | input | 1 | System clock (50 MHz) |
| sys_rst_n | input | 1 | Active-low reset, system domain |
| frame_ready | output | 1 | One-cycle pulse when a frame is handed over |
| frame_bank | output | 1 | Bank the consumer reads |
| rd_addr | input | 11 | Consumer read address within the bank |
| rd_data | output | 8 | Registered read data |

## Verification
A wrong framer state does not show up on the bus pins. It shows up as a frame whose bytes are shifted by one or more positions, or as a frame_ready pulse that arrives too early or never. That becomes visible one full frame later, so each stored bank is compared byte for byte against the expected payload.

A bus state error shows up within one or two bus clocks as a misordered enable and read strobe. Checks on every burst catch that at once.

The mapping from toggle to bank shows up as a wrong frame_bank on the first handover.

// File: rtl/frx_pkg.sv
`timescale 1ns/1ps
package frx_pkg;
    typedef enum logic [1:0] {BUS_IDLE, BUS_OE, BUS_READ} bus_state_t;
    typedef enum logic [1:0] {FR_HUNT, FR_CMD, FR_DATA} frame_state_t;
endpackage

// File: rtl/frx_bus_fsm.sv
`timescale 1ns/1ps
module frx_bus_fsm
    import frx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rxf_n,
    output logic oe_n,
    output logic rd_n,
    output logic byte_valid
);
    bus_state_t state, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= BUS_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        state_d = state;
        unique case (state)
            BUS_IDLE: if (!rxf_n) state_d = BUS_OE;
            BUS_OE:   state_d = rxf_n ? BUS_IDLE : BUS_READ;
            BUS_READ: if (rxf_n) state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // Moore strobes; a byte counts only when the flag is still low at the edge
    always_comb begin
        oe_n       = (state == BUS_IDLE);
        rd_n       = (state != BUS_READ);
        byte_valid = (state == BUS_READ) && !rxf_n;
    end
endmodule

// File: rtl/frx_framer.sv
`timescale 1ns/1ps
module frx_framer
    import frx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int PAYLOAD_LEN = 2048,
    parameter int SYNC_COUNT  = 3,
    parameter logic [DATA_W-1:0] SYNC_BYTE = 8'hA5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          byte_valid,
    input  logic [DATA_W-1:0]             data,
    output logic                          we,
    output logic [$clog2(PAYLOAD_LEN)-1:0] waddr,
    output logic                          wbank
);
    localparam int AW = $clog2(PAYLOAD_LEN);
    localparam int CW = $clog2(SYNC_COUNT + 1);
    localparam logic [AW-1:0] LAST_ADDR = AW'(PAYLOAD_LEN - 1);
    localparam logic [CW-1:0] LAST_SYNC = CW'(SYNC_COUNT - 1);

    frame_state_t  state, state_d;
    logic [CW-1:0] cnt, cnt_d;
    logic [AW-1:0] addr, addr_d;
    logic          bank, bank_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FR_HUNT;
            cnt   <= '0;
            addr  <= '0;
            bank  <= 1'b0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
            addr  <= addr_d;
            bank  <= bank_d;
        end
    end

    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        addr_d  = addr;
        bank_d  = bank;
        we      = 1'b0;
        if (byte_valid) begin
            unique case (state)
                FR_HUNT: begin
                    addr_d = '0;
                    if (data == SYNC_BYTE) begin
                        if (cnt == LAST_SYNC) begin
                            cnt_d   = '0;
                            state_d = FR_CMD;
                        end else begin
                            cnt_d = cnt + 1'b1;
                        end
                    end else begin
                        cnt_d = '0;
                    end
                end
                FR_CMD: begin
                    addr_d  = '0;
                    state_d = FR_DATA;
                end
                FR_DATA: begin
                    we = 1'b1;
                    if (addr == LAST_ADDR) begin
                        addr_d  = '0;
                        bank_d  = ~bank;
                        state_d = FR_HUNT;
                    end else begin
                        addr_d = addr + 1'b1;
                    end
                end
                default: state_d = FR_HUNT;
            endcase
        end
    end

    assign waddr = addr;
    assign wbank = bank;
endmodule

// File: rtl/frx_bank_mem.sv
`timescale 1ns/1ps
module frx_bank_mem #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2048
) (
    input  logic                     wclk,
    input  logic                     we,
    input  logic                     wbank,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     rclk,
    input  logic                     rbank,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DATA_W-1:0]        rdata
);
    localparam int AW = $clog2(DEPTH);
    logic [DATA_W-1:0] mem [2*DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[{wbank, waddr}] <= wdata;
    end

    always_ff @(posedge rclk) begin
        rdata <= mem[{rbank, raddr}];
    end
endmodule

// File: rtl/frx_bank_sync.sv
`timescale 1ns/1ps
module frx_bank_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic prod_bank,
    output logic frame_ready,
    output logic frame_bank
);
    logic s1, s2, s3;
    logic edge_seen;

    assign edge_seen = s2 ^ s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1          <= 1'b0;
            s2          <= 1'b0;
            s3          <= 1'b0;
            frame_ready <= 1'b0;
            frame_bank  <= 1'b1;
        end else begin
            s1          <= prod_bank;
            s2          <= s1;
            s3          <= s2;
            frame_ready <= edge_seen;
            if (edge_seen) frame_bank <= ~s2;
        end
    end
endmodule

// File: rtl/frame_fifo_rx.sv
`timescale 1ns/1ps
module frame_fifo_rx #(
    parameter int DATA_W      = 8,
    parameter int PAYLOAD_LEN = 2048,
    parameter int SYNC_COUNT  = 3,
    parameter logic [DATA_W-1:0] SYNC_BYTE = 8'hA5,
    localparam int AW = $clog2(PAYLOAD_LEN)
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              rxf_n,
    input  logic [DATA_W-1:0] bus_data,
    output logic              oe_n,
    output logic              rd_n,
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    output logic              frame_ready,
    output logic              frame_bank,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic          byte_valid;
    logic          we;
    logic [AW-1:0] waddr;
    logic          wbank;

    frx_bus_fsm u_bus (
        .clk        (bus_clk),
        .rst_n      (bus_rst_n),
        .rxf_n      (rxf_n),
        .oe_n       (oe_n),
        .rd_n       (rd_n),
        .byte_valid (byte_valid)
    );

    frx_framer #(
        .DATA_W      (DATA_W),
        .PAYLOAD_LEN (PAYLOAD_LEN),
        .SYNC_COUNT  (SYNC_COUNT),
        .SYNC_BYTE   (SYNC_BYTE)
    ) u_framer (
        .clk        (bus_clk),
        .rst_n      (bus_rst_n),
        .byte_valid (byte_valid),
        .data       (bus_data),
        .we         (we),
        .waddr      (waddr),
        .wbank      (wbank)
    );

    frx_bank_mem #(
        .DATA_W (DATA_W),
        .DEPTH  (PAYLOAD_LEN)
    ) u_mem (
        .wclk  (bus_clk),
        .we    (we),
        .wbank (wbank),
        .waddr (waddr),
        .wdata (bus_data),
        .rclk  (sys_clk),
        .rbank (frame_bank),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    frx_bank_sync u_sync (
        .clk         (sys_clk),
        .rst_n       (sys_rst_n),
        .prod_bank   (wbank),
        .frame_ready (frame_ready),
        .frame_bank  (frame_bank)
    );
endmodule

// File: rtl/frx_checker.sv
`timescale 1ns/1ps
module frx_checker (
    input logic bus_clk,
    input logic bus_rst_n,
    input logic rxf_n,
    input logic oe_n,
    input logic rd_n,
    input logic sys_clk,
    input logic sys_rst_n,
    input logic frame_ready,
    input logic frame_bank
);
    // R1
    idle_hold_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (oe_n && rxf_n) |=> oe_n);

    // R2
    oe_first_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $fell(oe_n) |-> rd_n);

    // R2
    rd_after_oe_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $fell(rd_n) |-> $past(!oe_n));

    // R3
    release_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (rxf_n && !rd_n) |=> (rd_n && oe_n));

    // R9
    bank_hold_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !frame_ready |-> $stable(frame_bank));

    // R9
    ready_pulse_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        frame_ready |=> !frame_ready);
endmodule

bind frame_fifo_rx frx_checker u_frx_chk (
    .bus_clk     (bus_clk),
    .bus_rst_n   (bus_rst_n),
    .rxf_n       (rxf_n),
    .oe_n        (oe_n),
    .rd_n        (rd_n),
    .sys_clk     (sys_clk),
    .sys_rst_n   (sys_rst_n),
    .frame_ready (frame_ready),
    .frame_bank  (frame_bank)
);

// File: tb/tb_frame_fifo_rx.sv
`timescale 1ns/1ps
module tb_frame_fifo_rx;
    localparam int LEN = 2048;
    localparam logic [7:0] SYNC = 8'hA5;

    logic bus_clk = 1'b0, sys_clk = 1'b0;
    logic bus_rst_n = 1'b0, sys_rst_n = 1'b0;
    logic rxf_n = 1'b1;
    logic [7:0] bus_data = 8'h00;
    logic oe_n, rd_n, frame_ready, frame_bank;
    logic [10:0] rd_addr = '0;
    logic [7:0] rd_data;

    always #8  bus_clk = ~bus_clk;
    always #10 sys_clk = ~sys_clk;

    frame_fifo_rx dut (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .rxf_n(rxf_n), .bus_data(bus_data),
        .oe_n(oe_n), .rd_n(rd_n), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
        .frame_ready(frame_ready), .frame_bank(frame_bank),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int checks = 0, errors = 0;
    logic [7:0] stream [0:16383];
    int wr_len = 0, rd_idx = 0;
    bit gaps_on = 1'b0, cap_pend = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int bus_cyc = 0, oe_fall_cyc = 0;
    logic prev_oe = 1'b1, prev_rd = 1'b1, prev_rxf = 1'b1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int f, input int i);
        return 8'(i * 7 + f * 13 + (i >> 8));
    endfunction

    // bridge model plus bus monitor, one process at the falling edge
    always @(negedge bus_clk) begin
        bus_cyc++;
        if (bus_rst_n) begin
            if (prev_oe && !oe_n) oe_fall_cyc = bus_cyc;
            // R2: read strobe one clock after output enable
            if (prev_rd && !rd_n)
                check(bus_cyc - oe_fall_cyc == 1, "R2", "oe-to-rd spacing",
                      bus_cyc - oe_fall_cyc, 1);
            // R3: flag high while reading releases both strobes
            if (prev_rxf && !prev_rd)
                check(rd_n && oe_n, "R3", "strobes after flag rise", {rd_n, oe_n}, 3);
        end
        if (cap_pend) rd_idx++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rxf_n = (rd_idx >= wr_len) || (gaps_on && lfsr[1:0] == 2'b00);
        bus_data = stream[rd_idx];
        cap_pend = bus_rst_n && !rd_n && !rxf_n;
        prev_oe = oe_n; prev_rd = rd_n; prev_rxf = rxf_n;
    end

    task automatic push_byte(input logic [7:0] b);
        stream[wr_len] = b;
        wr_len++;
    endtask

    task automatic push_frame(input int f, input logic [7:0] cmd, input int n);
        repeat (3) push_byte(SYNC);
        push_byte(cmd);
        for (int i = 0; i < n; i++) push_byte(exp_byte(f, i));
    endtask

    task automatic wait_ready(input string req, input logic exp_bank);
        int t = 0;
        @(negedge sys_clk);
        while (!frame_ready && t < 60000) begin
            @(negedge sys_clk);
            t++;
        end
        check(frame_ready, req, "frame_ready pulse seen", frame_ready, 1);
        check(frame_bank == exp_bank, "R8", "handed-over bank", frame_bank, exp_bank);
        @(negedge sys_clk);
        check(!frame_ready, "R9", "ready pulse width one cycle", frame_ready, 0);
    endtask

    task automatic verify_bank(input int f, input string req);
        int bad = 0, first_bad = -1, bad_val = 0;
        logic [7:0] b0 = 8'h00;
        for (int i = 0; i <= LEN; i++) begin
            @(negedge sys_clk);
            if (i > 0) begin
                if (i == 1) b0 = rd_data;
                if (rd_data !== exp_byte(f, i - 1)) begin
                    if (bad == 0) begin first_bad = i - 1; bad_val = rd_data; end
                    bad++;
                end
            end
            if (i < LEN) rd_addr = 11'(i);
        end
        // R4: no empty byte ahead of the payload
        check(b0 == exp_byte(f, 0), "R4", "payload byte 0", b0, exp_byte(f, 0));
        check(bad == 0, req, $sformatf("bank content (first bad addr %0d, value %0d)",
              first_bad, bad_val), bad, 0);
    endtask

    task automatic t_reset();
        repeat (10) @(negedge bus_clk);
        check(oe_n && rd_n, "R1", "strobes idle after reset", {oe_n, rd_n}, 3);
        check(!frame_ready, "R1", "frame_ready after reset", frame_ready, 0);
        check(frame_bank == 1'b1, "R1", "frame_bank after reset", frame_bank, 1);
    endtask

    task automatic t_clean_frame();
        gaps_on = 1'b0;
        push_frame(0, 8'h3C, LEN);
        wait_ready("R7", 1'b0);
        verify_bank(0, "R7");
    endtask

    task automatic t_bad_sync_cmd_sync();
        gaps_on = 1'b1;
        // R5: broken sync runs must not start a frame
        push_byte(8'h11); push_byte(SYNC); push_byte(SYNC); push_byte(8'h7E);
        push_byte(SYNC); push_byte(8'h22);
        // R6: command byte equal to the sync value is still dropped
        push_frame(1, SYNC, LEN);
        wait_ready("R5", 1'b1);
        verify_bank(1, "R6");
    endtask

    task automatic t_gapped_frame();
        gaps_on = 1'b1;
        push_byte(8'h00); push_byte(8'hFF);
        push_frame(2, 8'h00, LEN);
        wait_ready("R10", 1'b0);
        verify_bank(2, "R10");
    endtask

    task automatic t_resync();
        gaps_on = 1'b1;
        push_frame(9, 8'h01, LEN - 2);   // two bytes lost
        push_frame(10, 8'h02, LEN);      // partly swallowed, then skipped
        push_frame(3, 8'h03, LEN);
        wait_ready("R8", 1'b1);          // damaged frame still handed over
        wait_ready("R11", 1'b0);
        verify_bank(3, "R11");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge sys_clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete, actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge sys_clk);
        bus_rst_n = 1'b1;
        sys_rst_n = 1'b1;
        t_reset();
        t_clean_frame();
        t_bad_sync_cmd_sync();
        t_gapped_frame();
        t_resync();
        repeat (20) @(negedge sys_clk);
        finish_run();
    end
endmodule